// File: doc/BRIEF.md
# Sampling-Clock Tuning and Drive Control Register

This block is a 16-bit host control register for an e.MMC host controller. Software reaches it through a simple write/read strobe port at a single address. Through it, software starts and aborts the sampling-clock tuning handshake with an external tuning engine and selects the output driver strength. It also selects the HS200 speed mode and can hand driver-strength selection over to hardware preset values.

A tuning run starts when software writes 1 to the execute bit while no run is active. The block sends a one-cycle start pulse and clears the sampling-clock select. The execute bit stays set until the engine returns a done pulse. The done pulse carries a pass/fail result, and that result becomes the new sampling-clock select. Writing 0 to the execute bit during a run aborts it. Software can only clear the sampling-clock select; a write of 1 to it has no effect. The select never changes while a response or a read block is being received. Any pending change waits until reception has ended.

When the preset-enable bit is set, the effective driver strength is taken from a preset entry indexed by the HS200 field. When it is clear, the effective driver strength is the value software wrote. The HS200 field accepts 0 and 0xB as legal values. Any other value is stored, but it raises a sticky flag.

Top module: `hostctl_tune_reg`

## Requirements
- R1: After a synchronous reset, the register reads 0x0000 and every output is 0.
- R2: A write with bit 6 (execute) = 1 while no tuning run is active produces a one-cycle `tune_start_o` pulse on the cycle after the write edge. Bit 6 then reads 1, and the sampling-clock select (bit 7) is cleared.
- R3: While a run is active, a write with bit 6 = 0 aborts it. The block sends a one-cycle `tune_abort_o` pulse, bit 6 clears and bit 7 is forced to 0. A write with bit 6 = 1 during a run creates no new start.
- R4: A `tune_done_i` pulse during a run clears bit 6 and loads bit 7 with `tune_pass_i` (1 = tuned clock, 0 = fixed clock). A done pulse while no run is active is ignored.
- R5: A software write of 1 to bit 7 is ignored. A write of 0 to bit 7 clears it.
- R6: While `rx_busy_i` is high, `samp_sel_o` holds its value. A change requested meanwhile is applied on the first clock edge at which `rx_busy_i` is low.
- R7: With bit 15 (preset enable) = 0, the effective driver strength (bits 5:4 and `drv_strength_o`) is the written value, encoded 0 = type B, 1 = type A, 2 = type C, 3 = type D.
- R8: With bit 15 = 1, the effective driver strength is preset entry n. The entry sits at bits [2n+1:2n] of `preset_drv_i`, and n is the HS200 field (bits 3:0). A field value at or above the entry count selects entry 0.
- R9: `hs200_active_o` is 1 exactly when the HS200 field equals 0xB and `ddr_mode_i` was 0 on the previous cycle.
- R10: A write of an HS200 field value other than 0x0 or 0xB stores the value and sets `illegal_o`. The flag stays set until reset.
- R11: Bits 14:8 always read 0, and writes to them have no effect.
- R12: A read strobe at the register offset (0x3E) returns the register value on `rdata_o` one cycle later. At any other address, or with no strobe, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| tune_start_o | output | 1 | One-cycle request to begin tuning |
| tune_abort_o | output | 1 | One-cycle request to abandon tuning |
| tune_done_i | input | 1 | Tuning engine finished |
| tune_pass_i | input | 1 | Result that comes with the done pulse |
| rx_busy_i | input | 1 | Response or read block being received |
| samp_sel_o | output | 1 | 1 = tuned sampling clock, 0 = fixed clock |
| ddr_mode_i | input | 1 | DDR transfer mode is on |
| preset_drv_i | input | PRESET_CNT*2 | Packed preset driver-strength entries |
| drv_strength_o | output | 2 | Effective driver strength |
| hs200_active_o | output | 1 | HS200 mode in effect |
| illegal_o | output | 1 | Sticky illegal HS200 setting flag |

## Verification
The start and abort pulses, the execute bit and the sampling-clock select (when reception is idle) are all due on the first edge after the write or done pulse. The bench samples them at the falling edge that follows. The effective driver strength and `hs200_active_o` pass through one more register, so they are due a cycle later. Read data takes one further cycle after the strobe. The read task therefore inserts an idle cycle before raising the strobe and samples `rdata_o` at the falling edge after the capturing edge. For deferred select updates, the bench holds `rx_busy_i` high over several edges and confirms the old value each time. It then checks the new value at the falling edge right after the first non-busy edge.

// File: rtl/hostctl_pkg.sv
package hostctl_pkg;
  localparam int REG_W    = 16;
  localparam int DRV_W    = 2;
  localparam int SEL_W    = 4;
  localparam int BIT_PRE  = 15;
  localparam int BIT_SCLK = 7;
  localparam int BIT_EXEC = 6;
  localparam int DRV_LSB  = 4;
  localparam int SEL_LSB  = 0;
  localparam logic [SEL_W-1:0] HS200_CODE = 4'hB;

  typedef enum logic [DRV_W-1:0] {
    DRV_TYPE_B = 2'd0,
    DRV_TYPE_A = 2'd1,
    DRV_TYPE_C = 2'd2,
    DRV_TYPE_D = 2'd3
  } drv_e;
endpackage

// File: rtl/hct_tune_ctrl.sv
module hct_tune_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit_i,
  input  logic wr_exec_i,
  input  logic wr_sclk_i,
  input  logic done_i,
  input  logic pass_i,
  input  logic rx_busy_i,
  output logic exec_o,
  output logic sclk_o,
  output logic start_o,
  output logic abort_o
);
  logic exec_q, sclk_q, pend_q, pend_val_q;
  logic start_req, abort_req, done_ok;
  logic evt, evt_val, want, want_val;

  always_comb begin
    start_req = wr_hit_i && wr_exec_i && !exec_q;
    abort_req = wr_hit_i && !wr_exec_i && exec_q;
    done_ok   = done_i && exec_q && !abort_req;
    evt       = 1'b0;
    evt_val   = 1'b0;
    if (start_req || abort_req) begin
      evt = 1'b1;
    end else if (done_ok) begin
      evt     = 1'b1;
      evt_val = pass_i;
    end else if (wr_hit_i && !wr_sclk_i) begin
      evt = 1'b1;
    end
    want     = evt || pend_q;
    want_val = evt ? evt_val : pend_val_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_q     <= 1'b0;
      sclk_q     <= 1'b0;
      pend_q     <= 1'b0;
      pend_val_q <= 1'b0;
      start_o    <= 1'b0;
      abort_o    <= 1'b0;
    end else begin
      start_o <= start_req;
      abort_o <= abort_req;
      if (start_req)                 exec_q <= 1'b1;
      else if (abort_req || done_ok) exec_q <= 1'b0;
      if (want && !rx_busy_i) begin
        sclk_q <= want_val;
        pend_q <= 1'b0;
      end else if (want) begin
        pend_q     <= 1'b1;
        pend_val_q <= want_val;
      end
    end
  end

  assign exec_o = exec_q;
  assign sclk_o = sclk_q;
endmodule

// File: rtl/hct_preset_mux.sv
module hct_preset_mux #(
  parameter int PRESET_CNT = 16,
  parameter int DRV_W      = 2,
  parameter int SEL_W      = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pre_en_i,
  input  logic [DRV_W-1:0]           drv_user_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [PRESET_CNT*DRV_W-1:0] preset_i,
  output logic [DRV_W-1:0]           drv_o
);
  logic [DRV_W-1:0] pick;

  generate
    if (PRESET_CNT >= (1 << SEL_W)) begin : g_full
      assign pick = preset_i[sel_i*DRV_W +: DRV_W];
    end else begin : g_part
      assign pick = (32'(sel_i) < PRESET_CNT) ? preset_i[sel_i*DRV_W +: DRV_W]
                                               : preset_i[DRV_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) drv_o <= '0;
    else     drv_o <= pre_en_i ? pick : drv_user_i;
  end
endmodule

// File: rtl/hostctl_tune_reg.sv
module hostctl_tune_reg
  import hostctl_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h3E,
  parameter int                PRESET_CNT = 16,
  localparam int               PRESET_W   = PRESET_CNT * DRV_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  output logic                tune_start_o,
  output logic                tune_abort_o,
  input  logic                tune_done_i,
  input  logic                tune_pass_i,
  input  logic                rx_busy_i,
  output logic                samp_sel_o,
  input  logic                ddr_mode_i,
  input  logic [PRESET_W-1:0] preset_drv_i,
  output logic [DRV_W-1:0]    drv_strength_o,
  output logic                hs200_active_o,
  output logic                illegal_o
);
  logic             wr_hit, rd_hit;
  logic             pre_en_q;
  drv_e             drv_user_q;
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] wr_sel;
  logic             exec_bit;
  logic             unused_rsvd;

  assign wr_hit      = wr_en_i && (addr_i == REG_OFFSET);
  assign rd_hit      = rd_en_i && (addr_i == REG_OFFSET);
  assign wr_sel      = wdata_i[SEL_LSB +: SEL_W];
  assign unused_rsvd = ^wdata_i[14:8];

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_en_q   <= 1'b0;
      drv_user_q <= DRV_TYPE_B;
      sel_q      <= '0;
      illegal_o  <= 1'b0;
    end else if (wr_hit) begin
      pre_en_q   <= wdata_i[BIT_PRE];
      drv_user_q <= drv_e'(wdata_i[DRV_LSB +: DRV_W]);
      sel_q      <= wr_sel;
      if (wr_sel != '0 && wr_sel != HS200_CODE) illegal_o <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hs200_active_o <= 1'b0;
    else     hs200_active_o <= (sel_q == HS200_CODE) && !ddr_mode_i;
  end

  hct_tune_ctrl i_tune (
    .clk       (clk),
    .rst       (rst),
    .wr_hit_i  (wr_hit),
    .wr_exec_i (wdata_i[BIT_EXEC]),
    .wr_sclk_i (wdata_i[BIT_SCLK]),
    .done_i    (tune_done_i),
    .pass_i    (tune_pass_i),
    .rx_busy_i (rx_busy_i),
    .exec_o    (exec_bit),
    .sclk_o    (samp_sel_o),
    .start_o   (tune_start_o),
    .abort_o   (tune_abort_o)
  );

  hct_preset_mux #(
    .PRESET_CNT (PRESET_CNT),
    .DRV_W      (DRV_W),
    .SEL_W      (SEL_W)
  ) i_preset (
    .clk        (clk),
    .rst        (rst),
    .pre_en_i   (pre_en_q),
    .drv_user_i (drv_user_q),
    .sel_i      (sel_q),
    .preset_i   (preset_drv_i),
    .drv_o      (drv_strength_o)
  );

  always_ff @(posedge clk) begin
    if (rst)         rdata_o <= '0;
    else if (rd_hit) rdata_o <= {pre_en_q, 7'b0, samp_sel_o, exec_bit, drv_strength_o, sel_q};
    else             rdata_o <= '0;
  end
endmodule

// File: rtl/hct_checker.sv
module hct_checker (
  input logic       clk,
  input logic       rst,
  input logic       tune_start_o,
  input logic       tune_abort_o,
  input logic       samp_sel_o,
  input logic       rx_busy_i,
  input logic       illegal_o,
  input logic       hs200_active_o,
  input logic       ddr_mode_i,
  input logic [6:0] rsvd_bits
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst) tune_start_o |=> !tune_start_o); // R2
  AST_START_ABORT_EXCL: assert property (@(posedge clk) disable iff (rst) !(tune_start_o && tune_abort_o)); // R3
  AST_ABORT_FIXED_CLK: assert property (@(posedge clk) disable iff (rst) (tune_abort_o && !$past(rx_busy_i)) |-> !samp_sel_o); // R3
  AST_SEL_HELD_BUSY: assert property (@(posedge clk) disable iff (rst) rx_busy_i |=> $stable(samp_sel_o)); // R6
  AST_HS200_NO_DDR: assert property (@(posedge clk) disable iff (rst) hs200_active_o |-> !$past(ddr_mode_i)); // R9
  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (rst) illegal_o |=> illegal_o); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst) rsvd_bits == 7'b0); // R11
endmodule

bind hostctl_tune_reg hct_checker i_chk (
  .clk            (clk),
  .rst            (rst),
  .tune_start_o   (tune_start_o),
  .tune_abort_o   (tune_abort_o),
  .samp_sel_o     (samp_sel_o),
  .rx_busy_i      (rx_busy_i),
  .illegal_o      (illegal_o),
  .hs200_active_o (hs200_active_o),
  .ddr_mode_i     (ddr_mode_i),
  .rsvd_bits      (rdata_o[14:8])
);

// File: tb/test_hostctl_tune_reg.sv
`timescale 1ns/1ps
module test_hostctl_tune_reg;
  localparam int PCNT = 16;
  localparam logic [7:0] OFF = 8'h3E;

  logic clk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic t_start, t_abort, t_done = 0, t_pass = 0, rx_busy = 0, samp, ddr = 0;
  logic [PCNT*2-1:0] preset = 0;
  logic [1:0] drv;
  logic hs_act, ill;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic m_exec = 0, m_sclk = 0, m_pre = 0, m_ill = 0;
  logic [1:0] m_drv = 0;
  logic [3:0] m_hs = 0;

  always #2.5 clk = ~clk;

  hostctl_tune_reg i_hostctl_tune_reg (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tune_start_o(t_start), .tune_abort_o(t_abort),
    .tune_done_i(t_done), .tune_pass_i(t_pass), .rx_busy_i(rx_busy), .samp_sel_o(samp),
    .ddr_mode_i(ddr), .preset_drv_i(preset), .drv_strength_o(drv),
    .hs200_active_o(hs_act), .illegal_o(ill)
  );

  function automatic logic [1:0] eff_drv();
    return m_pre ? preset[m_hs*2 +: 2] : m_drv;
  endfunction

  function automatic logic [15:0] exp_read();
    return {m_pre, 7'b0, m_sclk, m_exec, eff_drv(), m_hs};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d);
    logic es, ea;
    es = (a == OFF) && d[6] && !m_exec;
    ea = (a == OFF) && !d[6] && m_exec;
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    check("R2 start pulse", t_start, es);
    check("R3 abort pulse", t_abort, ea);
    if (a == OFF) begin
      m_pre = d[15]; m_drv = d[5:4]; m_hs = d[3:0];
      if (d[3:0] != 4'h0 && d[3:0] != 4'hB) m_ill = 1;
      if (es) begin m_exec = 1; m_sclk = 0; end
      else if (ea) begin m_exec = 0; m_sclk = 0; end
      else if (!d[7]) m_sclk = 0;
    end
    if (!rx_busy) check("R5 samp_sel after write", samp, m_sclk);
  endtask

  task automatic do_done(input logic p);
    t_done = 1; t_pass = p;
    @(posedge clk); @(negedge clk);
    t_done = 0;
    if (m_exec) begin m_exec = 0; m_sclk = p; end
    check("R4 samp_sel after done", samp, m_sclk);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [15:0] v);
    @(posedge clk); @(negedge clk);
    rd_en = 1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 0;
    v = rdata;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < PCNT; i++) preset[i*2 +: 2] = 2'($urandom);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 samp_sel", samp, 0);
    check("R1 drv", drv, 0);
    check("R1 hs200", hs_act, 0);
    check("R1 illegal", ill, 0);
    do_read(OFF, v); check("R1 readback", v, 16'h0000);

    // R2 start
    do_write(OFF, 16'h0040);
    do_read(OFF, v); check("R2 exec reads 1", v, exp_read());
    // R3 second start while running gives no pulse (checked in do_write)
    do_write(OFF, 16'h0040);
    // R4 done with pass
    do_done(1);
    do_read(OFF, v); check("R4 pass loads select", v, 16'h0080);
    // R5 writing 1 ignored, writing 0 clears
    do_write(OFF, 16'h0080);
    check("R5 write 1 keeps select", samp, 1);
    do_write(OFF, 16'h0000);
    check("R5 write 0 clears select", samp, 0);
    // R4 done while idle ignored
    do_done(1);
    check("R4 idle done ignored", samp, 0);
    // R4 fail result
    do_write(OFF, 16'h0040); do_done(0);
    check("R4 fail selects fixed", samp, 0);
    // R3 abort
    do_write(OFF, 16'h0040); do_done(1);
    do_write(OFF, 16'h00C0);
    do_write(OFF, 16'h0080);
    check("R3 abort select 0", samp, 0);
    do_read(OFF, v); check("R3 exec cleared", v, 16'h0000);

    // R6 deferred update
    do_write(OFF, 16'h0040); do_done(1);
    rx_busy = 1;
    do_write(OFF, 16'h0000);
    check("R6 held while busy", samp, 1);
    repeat (3) @(negedge clk);
    check("R6 still held", samp, 1);
    rx_busy = 0;
    @(posedge clk); @(negedge clk);
    check("R6 applied after busy", samp, 0);

    // R7 user drive
    do_write(OFF, 16'h0030);
    do_read(OFF, v); check("R7 user drive type D", v, 16'h0030);
    check("R7 drv port", drv, 2'd3);
    do_write(OFF, 16'h0010);
    do_read(OFF, v); check("R7 user drive type A", v, 16'h0010);

    // R8 preset override and R9 HS200
    do_write(OFF, 16'h800B);
    do_read(OFF, v); check("R8 preset drive", drv, preset[11*2 +: 2]);
    check("R8 preset readback", v, exp_read());
    check("R9 hs200 on", hs_act, 1);
    ddr = 1; @(posedge clk); @(negedge clk);
    check("R9 hs200 off in ddr", hs_act, 0);
    ddr = 0; @(posedge clk); @(negedge clk);
    check("R9 hs200 back on", hs_act, 1);
    check("R10 legal codes no flag", ill, 0);

    // R10 illegal sticky
    do_write(OFF, 16'h0005);
    check("R10 illegal set", ill, 1);
    do_write(OFF, 16'h0000);
    check("R10 illegal sticky", ill, 1);

    // R11 reserved bits
    do_write(OFF, 16'h7F00);
    do_read(OFF, v); check("R11 reserved read 0", v, 16'h0000);

    // R12 other address
    do_write(8'h3C, 16'h8031);
    do_read(8'h3C, v); check("R12 other addr reads 0", v, 16'h0000);
    do_read(OFF, v); check("R12 other addr write ignored", v, 16'h0000);

    // random mix for R2..R8
    for (int i = 0; i < 80; i++) begin
      if ($urandom_range(0, 2) == 0) do_done(1'($urandom));
      else do_write(OFF, 16'($urandom) & 16'hFFFF);
      do_read(OFF, v);
      check("R8 random readback", v, exp_read());
      check("R7 random drive", drv, eff_drv());
      check("R10 random flag", ill, m_ill);
    end

    finished = 1;
    finish_run();
  end
endmodule